// File: doc/BRIEF.md
# Pipeline Hazard Stall Controller

This block is the hazard control unit for an in-order pipeline with five stages: fetch, decode, execute, memory access and write-back. Each cycle it looks at the two source register indices of the instruction in decode. It compares them against the destination indices of the three older instructions in execute, memory and write-back, and decides whether decode must wait. It also handles a branch or jump that resolves as taken in execute. The block is purely combinational. Its four outputs drive the enables and clears of the program counter and of the two front pipeline registers in the same cycle.

A run-time pin selects between two policies. With forwarding off, any pending write to a register that decode reads causes a stall, until that write has left write-back. With forwarding on, the datapath supplies results through bypass paths. The only stall left is a load in execute whose loaded register is needed by decode: the value does not exist yet, so one bubble is required. Register zero is hard-wired and never counts as a dependency. A stage whose write-enable is low never counts as a source of a hazard.

When a stall is needed, the program counter and the fetch/decode register keep their values, and a no-op is sent into the decode/execute register. When a branch is taken in execute, the two younger instructions are on the wrong path. The fetch/decode register is cleared, a no-op is sent into decode/execute, and the program counter is left free to load the target. This holds even if a stall was requested in the same cycle.

Top module: `hazard_stall_ctl`

## Requirements
- R1: With `fwd_mode`=0, a stall is raised when `id_src_a` is nonzero and equals the destination of any of the execute, memory or write-back stages whose write-enable is 1.
- R2: Source B gets the same test independently, and the two results are ORed, so a match on B alone also stalls.
- R3: A source index of 0 never causes a stall, in either mode, even when a writing stage targets register 0.
- R4: A stage with its write-enable at 0 never causes a stall, even when its destination equals a source index.
- R5: With `fwd_mode`=1, a stall is raised only when `ex_is_load`=1, `ex_wr_en`=1 and `ex_dst` equals a nonzero source index. Matches in memory or write-back, and matches with a non-load in execute, raise no stall.
- R6: While stalling with no taken branch, the outputs are `pc_hold`=1, `ifid_hold`=1, `idex_bubble`=1 and `ifid_flush`=0.
- R7: When `ex_br_taken`=1, the outputs are `ifid_flush`=1, `idex_bubble`=1, `pc_hold`=0 and `ifid_hold`=0, whether or not a stall is requested.
- R8: With no hazard and no taken branch, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fwd_mode | input | 1 | 0: stall on every pending write; 1: bypass datapath present, stall only on a load-use conflict |
| id_src_a | input | IDX_W | First source register index of the decode instruction |
| id_src_b | input | IDX_W | Second source register index of the decode instruction |
| ex_dst | input | IDX_W | Destination index of the execute instruction |
| ex_wr_en | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a memory load |
| mem_dst | input | IDX_W | Destination index of the memory-stage instruction |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | IDX_W | Destination index of the write-back instruction |
| wb_wr_en | input | 1 | Write-back instruction writes a register |
| ex_br_taken | input | 1 | Branch or jump in execute resolved as taken |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| ifid_flush | output | 1 | Clear the fetch/decode register to a no-op |
| idex_bubble | output | 1 | Load a no-op (all write-enables clear) into decode/execute |

## Verification
The hardest case to reach is a taken branch in the same cycle as a stall request, and especially the load-use stall in forwarding mode. That stall needs a load flag, a write-enable and a matching nonzero index all at once. The branch test sets that exact load-use conflict and raises `ex_br_taken` on top of it, then confirms that the outputs follow the flush pattern and not the hold pattern. The forwarding test also places matching destinations in memory and write-back next to a non-load match in execute, to show that only the load path stalls.

// File: rtl/hz_pkg.sv
package hz_pkg;
   localparam int NUM_SRCS      = 2;
   localparam int NUM_WR_STAGES = 3;
   localparam int STG_EX        = 0;
   localparam int STG_MEM       = 1;
   localparam int STG_WB        = 2;

   typedef struct packed {
      logic pc_hold;
      logic ifid_hold;
      logic ifid_flush;
      logic idex_bubble;
   } hz_ctl_t;
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
   parameter int IDX_W = 5
) (
   input  logic [IDX_W-1:0] src,
   input  logic [IDX_W-1:0] dst,
   input  logic             dst_wr_en,
   output logic             hit
);
   localparam logic [IDX_W-1:0] ZERO_REG = '0;

   always_comb begin
      hit = dst_wr_en && (src != ZERO_REG) && (src == dst);
   end
endmodule

// File: rtl/hz_stall_decide.sv
module hz_stall_decide
   import hz_pkg::*;
#(
   parameter int IDX_W = 5
) (
   input  logic                                fwd_mode,
   input  logic [NUM_SRCS-1:0][IDX_W-1:0]      srcs,
   input  logic [NUM_WR_STAGES-1:0][IDX_W-1:0] dsts,
   input  logic [NUM_WR_STAGES-1:0]            wr_ens,
   input  logic                                ex_is_load,
   output logic                                stall
);
   logic [NUM_SRCS-1:0][NUM_WR_STAGES-1:0] hit;
   logic [NUM_SRCS-1:0]                    src_any;
   logic [NUM_SRCS-1:0]                    src_ex;
   logic                                   full_stall;
   logic                                   lu_stall;

   for (genvar s = 0; s < NUM_SRCS; s++) begin : g_src
      for (genvar t = 0; t < NUM_WR_STAGES; t++) begin : g_stg
         hz_src_match #(.IDX_W(IDX_W)) u_match (
            .src       (srcs[s]),
            .dst       (dsts[t]),
            .dst_wr_en (wr_ens[t]),
            .hit       (hit[s][t])
         );
      end
      assign src_any[s] = |hit[s];
      assign src_ex[s]  = hit[s][STG_EX];
   end

   always_comb begin
      full_stall = |src_any;
      lu_stall   = ex_is_load && (|src_ex);
      stall      = fwd_mode ? lu_stall : full_stall;
   end

   // R3: both sources on register zero can never stall
   always_comb begin
      p_zero_src_no_stall_r3: assert (!((srcs[0] == '0) && (srcs[1] == '0) && stall))
         else $error("R3 stall with zero sources");
   end

   // R4: no writing stage means no dependency
   always_comb begin
      p_no_writer_no_stall_r4: assert (!((wr_ens == '0) && stall))
         else $error("R4 stall with all write-enables low");
   end

   // R5: forwarding mode stalls only behind a load
   always_comb begin
      p_fwd_needs_load_r5: assert (!(fwd_mode && !ex_is_load && stall))
         else $error("R5 stall in forwarding mode without load");
   end
endmodule

// File: rtl/hz_ctl_out.sv
module hz_ctl_out
   import hz_pkg::*;
(
   input  logic    stall,
   input  logic    br_taken,
   output hz_ctl_t ctl
);
   always_comb begin
      ctl.ifid_flush  = br_taken;
      ctl.idex_bubble = br_taken || stall;
      ctl.pc_hold     = stall && !br_taken;
      ctl.ifid_hold   = stall && !br_taken;
   end
endmodule

// File: rtl/hazard_stall_ctl.sv
module hazard_stall_ctl
   import hz_pkg::*;
#(
   parameter int IDX_W = 5
) (
   input  logic             fwd_mode,
   input  logic [IDX_W-1:0] id_src_a,
   input  logic [IDX_W-1:0] id_src_b,
   input  logic [IDX_W-1:0] ex_dst,
   input  logic             ex_wr_en,
   input  logic             ex_is_load,
   input  logic [IDX_W-1:0] mem_dst,
   input  logic             mem_wr_en,
   input  logic [IDX_W-1:0] wb_dst,
   input  logic             wb_wr_en,
   input  logic             ex_br_taken,
   output logic             pc_hold,
   output logic             ifid_hold,
   output logic             ifid_flush,
   output logic             idex_bubble
);
   if (IDX_W < 1 || IDX_W > 8) begin : g_bad_width
      $error("hazard_stall_ctl: IDX_W must be within 1..8");
   end

   logic [NUM_SRCS-1:0][IDX_W-1:0]      srcs;
   logic [NUM_WR_STAGES-1:0][IDX_W-1:0] dsts;
   logic [NUM_WR_STAGES-1:0]            wr_ens;
   logic                                stall;
   hz_ctl_t                             ctl;

   always_comb begin
      srcs[0]        = id_src_a;
      srcs[1]        = id_src_b;
      dsts[STG_EX]   = ex_dst;
      dsts[STG_MEM]  = mem_dst;
      dsts[STG_WB]   = wb_dst;
      wr_ens[STG_EX] = ex_wr_en;
      wr_ens[STG_MEM]= mem_wr_en;
      wr_ens[STG_WB] = wb_wr_en;
   end

   hz_stall_decide #(.IDX_W(IDX_W)) u_decide (
      .fwd_mode   (fwd_mode),
      .srcs       (srcs),
      .dsts       (dsts),
      .wr_ens     (wr_ens),
      .ex_is_load (ex_is_load),
      .stall      (stall)
   );

   hz_ctl_out u_out (
      .stall    (stall),
      .br_taken (ex_br_taken),
      .ctl      (ctl)
   );

   assign pc_hold     = ctl.pc_hold;
   assign ifid_hold   = ctl.ifid_hold;
   assign ifid_flush  = ctl.ifid_flush;
   assign idex_bubble = ctl.idex_bubble;

   // R6: a stall without a branch freezes the front and bubbles the back
   always_comb begin
      p_stall_freeze_r6: assert (!(stall && !ex_br_taken) ||
                                 (pc_hold && ifid_hold && idex_bubble && !ifid_flush))
         else $error("R6 stall output pattern wrong");
   end

   // R7: a taken branch overrides any hold
   always_comb begin
      p_branch_wins_r7: assert (!ex_br_taken ||
                                (ifid_flush && idex_bubble && !pc_hold && !ifid_hold))
         else $error("R7 branch output pattern wrong");
   end

   // R2: a hit on source B alone in full-stall mode must stall
   always_comb begin
      p_src_b_stalls_r2: assert (!(!fwd_mode && (id_src_b != '0) && wb_wr_en &&
                                   (id_src_b == wb_dst)) || stall)
         else $error("R2 source B match did not stall");
   end
endmodule

// File: tb/test_hazard_stall_ctl.sv
module test_hazard_stall_ctl;
   localparam int CLK_PERIOD = 10;
   localparam int W = 5;

   logic         clk = 1'b0;
   logic         fwd_mode, ex_wr_en, ex_is_load, mem_wr_en, wb_wr_en, ex_br_taken;
   logic [W-1:0] id_src_a, id_src_b, ex_dst, mem_dst, wb_dst;
   logic         pc_hold, ifid_hold, ifid_flush, idex_bubble;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // output order: {pc_hold, ifid_hold, ifid_flush, idex_bubble}
   localparam logic [3:0] O_IDLE   = 4'b0000;
   localparam logic [3:0] O_STALL  = 4'b1101;
   localparam logic [3:0] O_BRANCH = 4'b0011;

   always #(CLK_PERIOD/2) clk = ~clk;

   hazard_stall_ctl #(.IDX_W(W)) i_hazard_stall_ctl (
      .fwd_mode(fwd_mode), .id_src_a(id_src_a), .id_src_b(id_src_b),
      .ex_dst(ex_dst), .ex_wr_en(ex_wr_en), .ex_is_load(ex_is_load),
      .mem_dst(mem_dst), .mem_wr_en(mem_wr_en),
      .wb_dst(wb_dst), .wb_wr_en(wb_wr_en), .ex_br_taken(ex_br_taken),
      .pc_hold(pc_hold), .ifid_hold(ifid_hold),
      .ifid_flush(ifid_flush), .idex_bubble(idex_bubble)
   );

   task automatic apply(input logic fm, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [W-1:0] exd, input logic exw, input logic exl,
                        input logic [W-1:0] md, input logic mw,
                        input logic [W-1:0] wd, input logic ww, input logic br);
      @(posedge clk);
      fwd_mode = fm; id_src_a = a; id_src_b = b;
      ex_dst = exd; ex_wr_en = exw; ex_is_load = exl;
      mem_dst = md; mem_wr_en = mw; wb_dst = wd; wb_wr_en = ww;
      ex_br_taken = br;
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [3:0] exp);
      logic [3:0] got;
      got = {pc_hold, ifid_hold, ifid_flush, idex_bubble};
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %b expected %b", req, got, exp);
      end
   endtask

   task automatic t_idle();
      apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      check("R8 idle after start", O_IDLE);
      apply(0, 4, 5, 6, 1, 0, 7, 1, 8, 1, 0);
      check("R8 distinct registers", O_IDLE);
   endtask

   task automatic t_full_src_a();
      apply(0, 3, 9, 3, 1, 0, 0, 0, 0, 0, 0);
      check("R1 A vs EX", O_STALL);
      apply(0, 3, 9, 0, 0, 0, 3, 1, 0, 0, 0);
      check("R1 A vs MEM", O_STALL);
      apply(0, 3, 9, 0, 0, 0, 0, 0, 3, 1, 0);
      check("R1 A vs WB / R6 pattern", O_STALL);
   endtask

   task automatic t_full_src_b();
      apply(0, 1, 7, 2, 1, 0, 4, 1, 7, 1, 0);
      check("R2 B vs WB only", O_STALL);
      apply(0, 1, 31, 31, 1, 0, 0, 0, 0, 0, 0);
      check("R2 B vs EX top index", O_STALL);
   endtask

   task automatic t_zero_reg();
      apply(0, 0, 0, 0, 1, 0, 0, 1, 0, 1, 0);
      check("R3 zero full mode", O_IDLE);
      apply(1, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0);
      check("R3 zero load fwd mode", O_IDLE);
   endtask

   task automatic t_we_low();
      apply(0, 6, 6, 6, 0, 0, 6, 0, 6, 0, 0);
      check("R4 all write-enables low", O_IDLE);
      apply(1, 6, 2, 6, 0, 1, 0, 0, 0, 0, 0);
      check("R4 load without write-enable", O_IDLE);
   endtask

   task automatic t_fwd_mode();
      apply(1, 3, 4, 3, 1, 0, 4, 1, 3, 1, 0);
      check("R5 non-load and older matches", O_IDLE);
      apply(1, 3, 4, 4, 1, 1, 0, 0, 0, 0, 0);
      check("R5 load-use on B", O_STALL);
      apply(1, 3, 4, 5, 1, 1, 3, 1, 4, 1, 0);
      check("R5 load to other register", O_IDLE);
   endtask

   task automatic t_branch();
      apply(0, 1, 2, 3, 1, 0, 0, 0, 0, 0, 1);
      check("R7 taken branch alone", O_BRANCH);
      apply(0, 3, 2, 3, 1, 0, 0, 0, 0, 0, 1);
      check("R7 branch with full stall", O_BRANCH);
      apply(1, 8, 2, 8, 1, 1, 0, 0, 0, 0, 1);
      check("R7 branch with load-use", O_BRANCH);
      apply(1, 8, 2, 8, 1, 1, 0, 0, 0, 0, 0);
      check("R6 load-use after branch drops", O_STALL);
   endtask

   initial begin
      fwd_mode = 0; id_src_a = 0; id_src_b = 0; ex_dst = 0; ex_wr_en = 0;
      ex_is_load = 0; mem_dst = 0; mem_wr_en = 0; wb_dst = 0; wb_wr_en = 0;
      ex_br_taken = 0;
      #1;
      check("R8 initial outputs", O_IDLE);
      t_idle();
      t_full_src_a();
      t_full_src_b();
      t_zero_reg();
      t_we_low();
      t_fwd_mode();
      t_branch();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (2000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired got hung expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule